// File: doc/BRIEF.md
# Bus-Idle Power-Down Controller

This block manages power for a memory-and-logic subsystem on an 8-bit microcontroller bus. It decides when the input buffers that carry address and data to the subsystem should be shut off. It decides when the memories may sit in standby. It also decides which bus strobes reach the programmable logic arrays. The memories and logic arrays are not part of the block. They appear only as the gated address, data and strobe outputs and as a memory enable.

Three power-down paths exist, each with a different reach:

- **Idle timeout.** A slow auxiliary clock drives an idle counter. When the bus has been quiet for a programmable number of slow cycles, the counter times out and the buffers go off. Any later strobe brings them back at once and restarts the count.
- **Forced bit.** A firmware control bit shuts the buffers off from the next bus-clock cycle. It does not depend on the slow clock. Only firmware can release it.
- **Chip select.** An external select line parks the memories in standby. The buffers stay on and the arrays are not affected.

Firmware can also block each strobe from the arrays individually. A turbo bit is passed out to the arrays.

Bus activity is detected in the bus-clock domain. It is stretched into a level and carried into the slow domain through a two-flop synchronizer. The timeout flag returns to the bus domain the same way. A strobe releases an idle power-down combinationally, without waiting for either crossing.

Top module: `bidle_pwrdn`

## Requirements
- R1: With the idle-timeout enable set (register 0, bit 1), after about `term` slow-clock cycles without any strobe, `buf_en` falls. The `term` value is register 2. The slow cycles are counted from when the activity stretch (STRETCH bus cycles after the last strobe) has ended.
- R2: While `buf_en` is low, `arr_addr` and `arr_data` read zero and `mem_en` is low, whatever the address and data inputs do.
- R3: Writing 1 to the forced bit (register 0, bit 0) makes `buf_en` low from the next cycle. No slow clock is needed. Bus strobes do not release it; only writing the bit to 0 does.
- R4: With `chip_sel` low, `mem_en` is low. If no power-down path is active, `buf_en` stays high and `arr_addr` follows `bus_addr`.
- R5: Register 1 holds one blocking bit per strobe: bit 0 read, bit 1 write, bit 2 program fetch, bit 3 address latch. A set bit holds the matching `arr_*` strobe at 0. A clear bit passes the strobe through unchanged.
- R6: The turbo bit (register 0, bit 2) drives `turbo`. It is 1 after reset.
- R7: `arr_ext` always equals `ext_in`, including during any power-down.
- R8: During an idle power-down that is not forced, any strobe raises `buf_en` in the same cycle.
- R9: Register 3 reads {5'b0, source[1:0], pd}. The source codes are 00 none, 01 timeout and 10 forced. Forced wins when both paths hold.
- R10: After reset, register 0 reads 8'h04, register 1 reads 0, register 2 reads TERM_RST, and register 3 reads 0.
- R11: Clearing the idle-timeout enable releases an idle power-down from the next cycle.
- R12: Writes to register 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Slow auxiliary clock for the idle counter |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_fetch | input | 1 | Program-fetch strobe, active high |
| bus_ale | input | 1 | Address-latch strobe, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| chip_sel | input | 1 | External select; low puts memories in standby |
| ext_in | input | EXT_W | Non-address inputs to the logic arrays |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| buf_en | output | 1 | Address/data input buffers on |
| mem_en | output | 1 | Memories active (not standby) |
| arr_rd | output | 1 | Read strobe to the arrays after blocking |
| arr_wr | output | 1 | Write strobe to the arrays after blocking |
| arr_fetch | output | 1 | Fetch strobe to the arrays after blocking |
| arr_ale | output | 1 | Address-latch strobe to the arrays after blocking |
| arr_addr | output | ADDR_W | Gated address to memories and arrays |
| arr_data | output | DATA_W | Gated data to memories and arrays |
| arr_ext | output | EXT_W | Non-address inputs to the arrays |
| turbo | output | 1 | Turbo mode select for the arrays |

## Verification
The forced path and the idle-timeout path can both hold in the same cycle. The bench provokes this by setting the forced bit while a timeout is already in force, then clearing it while the timeout remains. It also strobes the bus while both are set. The reference model judges each case: the buffers must stay off while the forced bit is set, the status source must read forced whenever that bit is set, and once it clears the status must fall back to timeout or none. Around the timeout threshold, the two clock-domain crossings make the exact cycle uncertain by a few slow cycles. The model treats that narrow window as unknown for the power-down outputs only.

// File: rtl/bipd_pkg.sv
package bipd_pkg;

  localparam int TERM_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_IDLE  = 2'd1,
    SRC_FORCE = 2'd2
  } pd_src_e;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_BLOCK = 2'd1;
  localparam logic [1:0] RA_TERM  = 2'd2;
  localparam logic [1:0] RA_STAT  = 2'd3;

  localparam int CTL_FORCE = 0;
  localparam int CTL_APD   = 1;
  localparam int CTL_TURBO = 2;

  // strobe order: bit0 read, bit1 write, bit2 fetch, bit3 address latch
  typedef struct packed {
    logic ale;
    logic fetch;
    logic wr;
    logic rd;
  } strobe_t;

  function automatic logic idle_expired(input logic [TERM_W-1:0] cnt,
                                        input logic [TERM_W-1:0] term);
    return cnt >= term;
  endfunction

  function automatic pd_src_e pick_src(input logic forced, input logic idle);
    if (forced)    return SRC_FORCE;
    else if (idle) return SRC_IDLE;
    else           return SRC_NONE;
  endfunction

  function automatic logic [7:0] status_byte(input logic pd, input pd_src_e src);
    return {5'b0, src, pd};
  endfunction

endpackage

// File: rtl/bipd_sync2.sv
module bipd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bipd_regs.sv
module bipd_regs
  import bipd_pkg::*;
#(
  parameter logic [TERM_W-1:0] TERM_RST = 8'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [7:0]        status_in,
  output logic              force_pd,
  output logic              apd_en,
  output logic              turbo,
  output logic [3:0]        blk,
  output logic [TERM_W-1:0] term,
  output logic [7:0]        reg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_pd <= 1'b0;
      apd_en   <= 1'b0;
      turbo    <= 1'b1;
      blk      <= '0;
      term     <= TERM_RST;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: begin
          force_pd <= reg_wdata[CTL_FORCE];
          apd_en   <= reg_wdata[CTL_APD];
          turbo    <= reg_wdata[CTL_TURBO];
        end
        RA_BLOCK: blk  <= reg_wdata[3:0];
        RA_TERM:  term <= reg_wdata[TERM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {5'b0, turbo, apd_en, force_pd};
      RA_BLOCK: reg_rdata = {4'b0, blk};
      RA_TERM:  reg_rdata = 8'(term);
      default:  reg_rdata = status_in;
    endcase
  end
endmodule

// File: rtl/bipd_act_stretch.sv
module bipd_act_stretch #(
  parameter int STRETCH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_act,
  output logic act_lvl
);
  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH);

  logic [SW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (bus_act)       left <= LOAD;
    else if (left != '0)    left <= left - 1'b1;
  end

  assign act_lvl = (left != '0);
endmodule

// File: rtl/bipd_idle_timer.sv
module bipd_idle_timer
  import bipd_pkg::*;
(
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              act_lvl,
  input  logic              apd_en,
  input  logic [TERM_W-1:0] term,
  output logic              timed,
  output logic [TERM_W-1:0] idle_cnt
);
  logic act_s, en_s;
  logic [TERM_W-1:0] cnt_next;

  bipd_sync2 #(.W(2)) u_sync_in (
    .clk  (slow_clk),
    .rst_n(rst_n),
    .d    ({act_lvl, apd_en}),
    .q    ({act_s, en_s})
  );

  always_comb cnt_next = (idle_cnt == '1) ? idle_cnt : idle_cnt + 1'b1;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      timed    <= 1'b0;
    end else if (!en_s || act_s) begin
      idle_cnt <= '0;
      timed    <= 1'b0;
    end else if (!timed) begin
      idle_cnt <= cnt_next;
      timed    <= idle_expired(cnt_next, term);
    end
  end
endmodule

// File: rtl/bipd_gate.sv
module bipd_gate
  import bipd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              buf_en,
  input  logic              chip_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  strobe_t           strb_in,
  input  logic [3:0]        blk,
  output strobe_t           strb_out,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              mem_en
);
  logic [3:0] s_in, s_out;
  assign s_in = strb_in;

  for (genvar i = 0; i < 4; i++) begin : g_blk
    assign s_out[i] = s_in[i] & ~blk[i];
  end

  assign strb_out = strobe_t'(s_out);
  assign arr_addr = buf_en ? bus_addr : '0;
  assign arr_data = buf_en ? bus_data : '0;
  assign mem_en   = buf_en & chip_sel;
endmodule

// File: rtl/bidle_pwrdn.sv
module bidle_pwrdn
  import bipd_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                EXT_W    = 4,
  parameter int                STRETCH  = 32,
  parameter logic [TERM_W-1:0] TERM_RST = 8'd32
) (
  input  logic              clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_fetch,
  input  logic              bus_ale,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              chip_sel,
  input  logic [EXT_W-1:0]  ext_in,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              buf_en,
  output logic              mem_en,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic              arr_fetch,
  output logic              arr_ale,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic [EXT_W-1:0]  arr_ext,
  output logic              turbo
);
  // named internal events, also used by the checker
  strobe_t           strb_in, strb_out;
  logic              bus_act, act_lvl, wake;
  logic              force_pd, apd_en;
  logic [3:0]        blk;
  logic [TERM_W-1:0] term, idle_cnt;
  logic              timed, timed_f;
  logic              pd_idle, pd_any;
  pd_src_e           pd_src;
  logic [7:0]        status;

  assign strb_in = '{ale: bus_ale, fetch: bus_fetch, wr: bus_wr, rd: bus_rd};
  assign bus_act = |strb_in;

  bipd_regs #(.TERM_RST(TERM_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status_in(status),
    .force_pd (force_pd),
    .apd_en   (apd_en),
    .turbo    (turbo),
    .blk      (blk),
    .term     (term),
    .reg_rdata(reg_rdata)
  );

  bipd_act_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_act(bus_act),
    .act_lvl(act_lvl)
  );

  bipd_idle_timer u_timer (
    .slow_clk(slow_clk),
    .rst_n   (rst_n),
    .act_lvl (act_lvl),
    .apd_en  (apd_en),
    .term    (term),
    .timed   (timed),
    .idle_cnt(idle_cnt)
  );

  bipd_sync2 #(.W(1)) u_sync_back (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (timed),
    .q    (timed_f)
  );

  assign wake    = bus_act | act_lvl;
  assign pd_idle = timed_f & apd_en & ~wake;
  assign pd_any  = force_pd | pd_idle;
  assign pd_src  = pick_src(force_pd, pd_idle);
  assign status  = status_byte(pd_any, pd_src);
  assign buf_en  = ~pd_any;

  bipd_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .buf_en  (buf_en),
    .chip_sel(chip_sel),
    .bus_addr(bus_addr),
    .bus_data(bus_data),
    .strb_in (strb_in),
    .blk     (blk),
    .strb_out(strb_out),
    .arr_addr(arr_addr),
    .arr_data(arr_data),
    .mem_en  (mem_en)
  );

  assign arr_rd    = strb_out.rd;
  assign arr_wr    = strb_out.wr;
  assign arr_fetch = strb_out.fetch;
  assign arr_ale   = strb_out.ale;
  assign arr_ext   = ext_in;
endmodule

// File: rtl/bipd_checker.sv
module bipd_checker
  import bipd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              slow_clk,
  input logic              rst_n,
  input logic              bus_act,
  input logic              force_pd,
  input logic              apd_en,
  input pd_src_e           pd_src,
  input logic              buf_en,
  input logic              mem_en,
  input logic              chip_sel,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [3:0]        blk,
  input logic              arr_rd,
  input logic              arr_ale,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic              timed,
  input logic [TERM_W-1:0] idle_cnt
);
  assert_timed_cnt_R1: assert property (@(posedge slow_clk) disable iff (!rst_n)
    timed |-> idle_cnt != '0);

  assert_pd_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |-> (arr_addr == '0 && !mem_en));

  assert_force_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_pd |-> !buf_en);

  assert_force_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (force_pd && !(reg_we && reg_addr == RA_CTRL)) |=> force_pd);

  assert_csel_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel && !force_pd && !apd_en) |-> (buf_en && !mem_en));

  assert_block_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk[0] |-> !arr_rd);

  assert_block_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk[3] |-> !arr_ale);

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !force_pd) |-> buf_en);

  assert_src_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_pd |-> pd_src == SRC_FORCE);

  assert_apd_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!apd_en && !force_pd) |-> buf_en);
endmodule

bind bidle_pwrdn bipd_checker #(.ADDR_W(ADDR_W)) u_bipd_chk (
  .clk     (clk),
  .slow_clk(slow_clk),
  .rst_n   (rst_n),
  .bus_act (bus_act),
  .force_pd(force_pd),
  .apd_en  (apd_en),
  .pd_src  (pd_src),
  .buf_en  (buf_en),
  .mem_en  (mem_en),
  .chip_sel(chip_sel),
  .arr_addr(arr_addr),
  .blk     (blk),
  .arr_rd  (arr_rd),
  .arr_ale (arr_ale),
  .reg_we  (reg_we),
  .reg_addr(reg_addr),
  .timed   (timed),
  .idle_cnt(idle_cnt)
);

// File: tb/bidle_pwrdn_bench.sv
module bidle_pwrdn_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int EXT_W  = 4;
  localparam int STRETCH = 32;
  localparam int TERM_RST = 32;

  logic clk = 0, slow_clk = 0, rst_n = 0;
  logic bus_rd = 0, bus_wr = 0, bus_fetch = 0, bus_ale = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_data = '0;
  logic chip_sel = 1;
  logic [EXT_W-1:0] ext_in = '0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 2'd3;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic buf_en, mem_en, arr_rd, arr_wr, arr_fetch, arr_ale, turbo;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;
  logic [EXT_W-1:0] arr_ext;

  bidle_pwrdn u_bidle_pwrdn (.*);

  always #5 clk = ~clk;
  initial begin #3; forever #20 slow_clk = ~slow_clk; end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int cyc = 0, last_act = -100000, slow_edges = 0, idle_base = 0;
  bit m_force = 0, m_apd = 0, m_turbo = 1;
  bit [3:0] m_blk = 0;
  bit [7:0] m_term = TERM_RST[7:0];

  always @(posedge slow_clk) slow_edges++;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_force = 0; m_apd = 0; m_turbo = 1; m_blk = 0; m_term = TERM_RST[7:0];
      last_act = -100000; idle_base = slow_edges;
    end else begin
      cyc++;
      if (reg_we) begin
        if (reg_addr == 2'd0) begin
          m_force = reg_wdata[0]; m_apd = reg_wdata[1]; m_turbo = reg_wdata[2];
        end else if (reg_addr == 2'd1) m_blk = reg_wdata[3:0];
        else if (reg_addr == 2'd2) m_term = reg_wdata;
      end
      if (bus_rd | bus_wr | bus_fetch | bus_ale) last_act = cyc;
      if (!m_apd || (cyc - last_act < STRETCH)) idle_base = slow_edges;
    end
  end

  always @(negedge clk) begin : every_clock
    int idle;
    bit wake, known, pdi, pd, b;
    bit [1:0] src;
    logic [7:0] rexp;
    if (rst_n) begin
      wake  = (bus_rd | bus_wr | bus_fetch | bus_ale) || (cyc - last_act < STRETCH);
      idle  = slow_edges - idle_base;
      known = 1; pdi = 0;
      if (m_apd && !wake) begin
        if (idle >= int'(m_term) + 4) pdi = 1;
        else if (idle > int'(m_term)) known = 0;
      end
      pd  = m_force | pdi;
      src = m_force ? 2'b10 : (pdi ? 2'b01 : 2'b00);
      b   = !pd;
      if (known || m_force) begin
        chk("R1 R3 R8 R11 buf_en", buf_en, b);
        chk("R2 R4 mem_en", mem_en, b & chip_sel);
        chk("R2 arr_addr", arr_addr, b ? bus_addr : '0);
        chk("R2 arr_data", arr_data, b ? bus_data : '0);
      end
      chk("R5 strobes", {arr_ale, arr_fetch, arr_wr, arr_rd},
          {bus_ale, bus_fetch, bus_wr, bus_rd} & ~m_blk);
      chk("R6 turbo", turbo, m_turbo);
      chk("R7 arr_ext", arr_ext, ext_in);
      case (reg_addr)
        2'd0: rexp = {5'b0, m_turbo, m_apd, m_force};
        2'd1: rexp = {4'b0, m_blk};
        2'd2: rexp = m_term;
        default: rexp = {5'b0, src, pd};
      endcase
      if (reg_addr != 2'd3 || known || m_force) chk("R9 R10 R12 reg_rdata", reg_rdata, rexp);
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic peek(); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    tick(); reg_we = 1; reg_addr = a; reg_wdata = d;
    tick(); reg_we = 0; reg_addr = 2'd3;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a; peek(); chk(tag, reg_rdata, exp); reg_addr = 2'd3;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10 reset values, R6 turbo default
    rd_chk("R10 ctrl reset", 2'd0, 8'h04);
    rd_chk("R10 block reset", 2'd1, 8'h00);
    rd_chk("R10 term reset", 2'd2, 8'(TERM_RST));
    rd_chk("R10 status reset", 2'd3, 8'h00);
    chk("R6 turbo reset", turbo, 1'b1);

    // R5 blocking patterns
    wr(2'd1, 8'h05);
    bus_rd = 1; bus_wr = 1; bus_fetch = 1; bus_ale = 1; peek();
    chk("R5 block 0101", {arr_ale, arr_fetch, arr_wr, arr_rd}, 4'b1010);
    wr(2'd1, 8'h0A); peek();
    chk("R5 block 1010", {arr_ale, arr_fetch, arr_wr, arr_rd}, 4'b0101);
    wr(2'd1, 8'h00); peek();
    chk("R5 no block", {arr_ale, arr_fetch, arr_wr, arr_rd}, 4'b1111);
    tick(); bus_rd = 0; bus_wr = 0; bus_fetch = 0; bus_ale = 0;

    // R4 chip select standby
    tick(); chip_sel = 0; bus_addr = 16'h1234; peek();
    chk("R4 mem_en standby", mem_en, 1'b0);
    chk("R4 buffers on", buf_en, 1'b1);
    chk("R4 addr passes", arr_addr, 16'h1234);
    tick(); chip_sel = 1;

    // R3 forced power-down
    wr(2'd0, 8'h05); peek();
    chk("R3 forced off", buf_en, 1'b0);
    tick(); bus_addr = 16'hBEEF; bus_data = 8'h5A; peek();
    chk("R2 addr blocked", arr_addr, 16'h0);
    chk("R2 mem off", mem_en, 1'b0);
    tick(); bus_rd = 1; peek();
    chk("R3 R8 strobe does not release forced", buf_en, 1'b0);
    tick(); bus_rd = 0; ext_in = 4'hA; peek();
    chk("R7 ext during forced", arr_ext, 4'hA);
    rd_chk("R9 forced status", 2'd3, 8'h05);
    wr(2'd0, 8'h04); peek();
    chk("R3 forced released", buf_en, 1'b1);

    // R12 status writes ignored
    wr(2'd3, 8'hFF);
    rd_chk("R12 ctrl kept", 2'd0, 8'h04);
    rd_chk("R12 block kept", 2'd1, 8'h00);
    rd_chk("R12 term kept", 2'd2, 8'(TERM_RST));

    // R6 turbo select
    wr(2'd0, 8'h00); peek(); chk("R6 turbo off", turbo, 1'b0);
    wr(2'd0, 8'h04); peek(); chk("R6 turbo on", turbo, 1'b1);

    // R1 idle timeout
    wr(2'd2, 8'd6);
    wr(2'd0, 8'h06);
    repeat (100) tick();
    peek(); chk("R1 idle timeout", buf_en, 1'b0);
    rd_chk("R9 idle status", 2'd3, 8'h03);
    tick(); bus_addr = 16'h00F0; ext_in = 4'h5; peek();
    chk("R2 addr blocked idle", arr_addr, 16'h0);
    chk("R2 mem off idle", mem_en, 1'b0);
    chk("R7 ext during idle", arr_ext, 4'h5);

    // R8 wake on strobe in the same cycle
    tick(); bus_ale = 1; peek();
    chk("R8 same-cycle wake", buf_en, 1'b1);
    chk("R8 addr restored", arr_addr, 16'h00F0);
    tick(); bus_ale = 0; peek();
    chk("R8 stays awake", buf_en, 1'b1);
    repeat (100) tick();
    peek(); chk("R1 timeout after restart", buf_en, 1'b0);

    // overlap: forced and timeout together
    wr(2'd0, 8'h07);
    rd_chk("R9 forced wins", 2'd3, 8'h05);
    wr(2'd0, 8'h06);
    rd_chk("R9 back to idle source", 2'd3, 8'h03);
    wr(2'd0, 8'h07);
    tick(); bus_wr = 1; peek();
    chk("R3 forced holds over strobe", buf_en, 1'b0);
    tick(); bus_wr = 0;
    wr(2'd0, 8'h06); peek();
    chk("R8 released after activity", buf_en, 1'b1);

    // R11 disable releases idle power-down
    repeat (100) tick();
    peek(); chk("R1 timeout again", buf_en, 1'b0);
    wr(2'd0, 8'h04); peek();
    chk("R11 disable releases", buf_en, 1'b1);
    repeat (20) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule